// File: doc/BRIEF.md
# Per-Module Corrected-Error Threshold Monitor

This block counts corrected-error events for the memory modules behind two channels. It keeps one saturating 15-bit counter for each of eight tracked units. After every event it compares the updated counter with a single programmable threshold. When a unit's count goes strictly above the threshold, the block sets a sticky overflow flag for that unit. On the cycle that any flag goes from clear to set, it issues a one-cycle interrupt pulse. The pulse goes to the system-management line or to the non-maskable line, depending on two enable bits.

A mode input selects how an event's channel, module and rank indices map onto the eight units. In one mode each unit is a whole module. In the other mode each unit covers a pair of ranks. A plain register port gives access to two words: a control word (threshold and enables) and a status word (overflow flags and the ID of a module that lost redundancy). Status fields are cleared by writing zeros.

Top module: `dimm_err_monitor`

## Requirements
- R1: After reset, both register words read 0, every counter is 0, and neither interrupt output is high.
- R2: The control word (cfg_addr=1) holds the threshold in bits 14:0, the system-management enable in bit 15 and the non-maskable enable in bit 16. All three fields read back exactly as written.
- R3: Each accepted event adds one to its unit's counter. The unit's flag is set on that edge only if the updated count is strictly greater than the threshold. A count equal to the threshold leaves the flag clear.
- R4: A counter that has reached 32767 stays at 32767 on further events and never wraps to 0.
- R5: With mode_pair=0, the unit index is chan*4 + module, so bits 0–3 serve channel 0 modules 0–3 and bits 4–7 serve channel 1 modules 0–3.
- R6: With mode_pair=1, the unit index is chan*4 + module[0]*2 + rank[1], so the units of a channel run in order: module 0 ranks 0–1, module 0 ranks 2–3, module 1 ranks 0–1, module 1 ranks 2–3. Module bit 1 is ignored.
- R7: The overflow flags sit in status bits 7:0 (cfg_addr=0). Writing a 0 to a flag clears it and writing a 1 has no effect. A hardware set in the same cycle as a clearing write wins.
- R8: A redundancy-loss strobe loads its 2-bit module ID into status bits 13:12 without raising an interrupt. Each of those bits is cleared by writing 0 to it.
- R9: One cycle after an edge on which at least one flag went from 0 to 1, exactly one pulse is issued: on smi_pulse if the system-management enable is set, otherwise on nmi_pulse if the non-maskable enable is set, otherwise on neither. Setting a flag that is already set gives no pulse.
- R10: Reserved bits of both words (control 31:17; status 31:14 and 11:8) read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_pair | input | 1 | 0: one unit per module; 1: one unit per rank pair |
| ev_valid | input | 1 | Corrected-error event strobe |
| ev_chan | input | 1 | Channel index of the event |
| ev_mod | input | 2 | Module index of the event |
| ev_rank | input | 2 | Rank index of the event |
| fault_vld | input | 1 | Redundancy-loss strobe |
| fault_id | input | 2 | ID of the module that lost redundancy |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 1 | Register select: 0 status, 1 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected word (combinational) |
| smi_pulse | output | 1 | One-cycle system-management interrupt |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt |

## Verification
The block has one edge of latency throughout. An event, write or redundancy-loss strobe that is presented before a rising edge updates the counter, status word and control word on that edge. The interrupt pulse comes from the same edge and is high for exactly the following cycle. Read data is combinational, so it reflects the selected word as soon as that word has been updated. The bench drives inputs on falling edges and advances its behavioural model on each rising edge. It compares the pulses and the read data 1 ns after that rising edge, and it samples directed expectations on the falling edge that follows the edge they depend on.

// File: rtl/dem_pkg.sv
package dem_pkg;

  typedef enum logic {
    SEL_STATUS  = 1'b0,
    SEL_CONTROL = 1'b1
  } reg_sel_e;

  // Unit index from event coordinates; pair mode folds rank pairs into units.
  function automatic int unsigned unit_of(input logic pair_mode,
                                          input int unsigned chan,
                                          input int unsigned mdl,
                                          input int unsigned rank,
                                          input int unsigned per_ch);
    int unsigned local_idx;
    if (pair_mode) local_idx = (mdl % 2) * 2 + (rank / 2);
    else           local_idx = mdl;
    return chan * per_ch + local_idx;
  endfunction

endpackage

// File: rtl/dem_unit_map.sv
module dem_unit_map #(
  parameter int NUM_CH      = 2,
  parameter int MODS_PER_CH = 4,
  parameter int CH_W        = 1,
  parameter int MOD_W       = 2,
  parameter int RANK_W      = 2,
  parameter int NUM_UNITS   = NUM_CH * MODS_PER_CH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_pair,
  input  logic                 ev_valid,
  input  logic [CH_W-1:0]      ev_chan,
  input  logic [MOD_W-1:0]     ev_mod,
  input  logic [RANK_W-1:0]    ev_rank,
  output logic [NUM_UNITS-1:0] hit_vec
);
  import dem_pkg::*;

  int unsigned unit_idx;

  always_comb begin
    unit_idx = unit_of(mode_pair, int'(ev_chan), int'(ev_mod), int'(ev_rank),
                       MODS_PER_CH);
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_hit
    assign hit_vec[u] = ev_valid && (unit_idx == u);
  end

  // R5/R6: every event lands on exactly one unit.
  assert_one_unit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $onehot(hit_vec));
  assert_no_stray_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (hit_vec == '0));

endmodule

// File: rtl/dem_err_counter.sv
module dem_err_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             set_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = sat_inc(cnt_q);
  assign set_o   = inc_i && (cnt_nxt > thr_i);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nxt;
  end

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_i |=> $stable(cnt_q));
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/dem_ctrl_regs.sv
module dem_ctrl_regs #(
  parameter int CNT_W     = 15,
  parameter int NUM_UNITS = 8,
  parameter int DATA_W    = 32,
  parameter int FID_LO    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  dem_pkg::reg_sel_e    cfg_sel,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic [NUM_UNITS-1:0] set_vec,
  input  logic                 fault_vld,
  input  logic [1:0]           fault_id,
  output logic [DATA_W-1:0]    cfg_rdata,
  output logic [CNT_W-1:0]     thr_o,
  output logic                 smi_pulse,
  output logic                 nmi_pulse
);
  import dem_pkg::*;

  localparam int SMI_BIT = CNT_W;
  localparam int NMI_BIT = CNT_W + 1;
  localparam int CTRL_W  = CNT_W + 2;

  logic [CTRL_W-1:0]    ctrl_q;
  logic [NUM_UNITS-1:0] ovf_q, ovf_keep, ovf_d, newly_set;
  logic [1:0]           fid_q, fid_d;
  logic                 wr_status, wr_ctrl, any_new, smi_en, nmi_en;
  logic                 smi_q, nmi_q;
  logic                 unused_wdata;

  assign wr_status = cfg_we && (cfg_sel == SEL_STATUS);
  assign wr_ctrl   = cfg_we && (cfg_sel == SEL_CONTROL);
  assign smi_en    = ctrl_q[SMI_BIT];
  assign nmi_en    = ctrl_q[NMI_BIT];
  assign thr_o     = ctrl_q[CNT_W-1:0];

  assign ovf_keep  = wr_status ? (ovf_q & cfg_wdata[NUM_UNITS-1:0]) : ovf_q;
  assign ovf_d     = ovf_keep | set_vec;
  assign newly_set = set_vec & ~ovf_q;
  assign any_new   = |newly_set;

  always_comb begin
    if (fault_vld)      fid_d = fault_id;
    else if (wr_status) fid_d = fid_q & cfg_wdata[FID_LO+1:FID_LO];
    else                fid_d = fid_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ovf_q  <= '0;
      fid_q  <= '0;
      smi_q  <= 1'b0;
      nmi_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= cfg_wdata[CTRL_W-1:0];
      ovf_q <= ovf_d;
      fid_q <= fid_d;
      smi_q <= any_new && smi_en;
      nmi_q <= any_new && nmi_en && !smi_en;
    end
  end

  assign smi_pulse = smi_q;
  assign nmi_pulse = nmi_q;

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel == SEL_CONTROL) begin
      cfg_rdata[CTRL_W-1:0] = ctrl_q;
    end else begin
      cfg_rdata[NUM_UNITS-1:0]     = ovf_q;
      cfg_rdata[FID_LO+1:FID_LO]   = fid_q;
    end
  end

  assign unused_wdata = ^{cfg_wdata[DATA_W-1:CTRL_W]};

  assert_single_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(smi_pulse && nmi_pulse));
  assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_pulse || nmi_pulse) |-> (|(ovf_q & ~$past(ovf_q))));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smi_en) && !$past(nmi_en)) |-> !(smi_pulse || nmi_pulse));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ovf_q) & ~ovf_q)) |-> $past(wr_status));
  assert_fid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_vld && !wr_status) |=> $stable(fid_q));

endmodule

// File: rtl/dimm_err_monitor.sv
module dimm_err_monitor #(
  parameter int CNT_W       = 15,
  parameter int NUM_CH      = 2,
  parameter int MODS_PER_CH = 4,
  parameter int RANKS       = 4,
  parameter int DATA_W      = 32,
  parameter int CH_W        = $clog2(NUM_CH),
  parameter int MOD_W       = $clog2(MODS_PER_CH),
  parameter int RANK_W      = $clog2(RANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pair,
  input  logic              ev_valid,
  input  logic [CH_W-1:0]   ev_chan,
  input  logic [MOD_W-1:0]  ev_mod,
  input  logic [RANK_W-1:0] ev_rank,
  input  logic              fault_vld,
  input  logic [1:0]        fault_id,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              smi_pulse,
  output logic              nmi_pulse
);
  import dem_pkg::*;

  localparam int NUM_UNITS = NUM_CH * MODS_PER_CH;

  logic [NUM_UNITS-1:0] hit_vec;
  logic [NUM_UNITS-1:0] set_vec;
  logic [CNT_W-1:0]     thr;

  dem_unit_map #(
    .NUM_CH(NUM_CH), .MODS_PER_CH(MODS_PER_CH), .CH_W(CH_W),
    .MOD_W(MOD_W), .RANK_W(RANK_W), .NUM_UNITS(NUM_UNITS)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .mode_pair(mode_pair), .ev_valid(ev_valid),
    .ev_chan(ev_chan), .ev_mod(ev_mod), .ev_rank(ev_rank), .hit_vec(hit_vec)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cnt
    dem_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc_i(hit_vec[u]), .thr_i(thr),
      .set_o(set_vec[u])
    );
  end

  dem_ctrl_regs #(
    .CNT_W(CNT_W), .NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W), .FID_LO(12)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(reg_sel_e'(cfg_addr)),
    .cfg_wdata(cfg_wdata), .set_vec(set_vec), .fault_vld(fault_vld),
    .fault_id(fault_id), .cfg_rdata(cfg_rdata), .thr_o(thr),
    .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse)
  );

endmodule

// File: tb/sim_dimm_err_monitor.sv
module sim_dimm_err_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pair = 1'b0, ev_valid = 1'b0;
  logic [0:0]  ev_chan = '0;
  logic [1:0]  ev_mod = '0, ev_rank = '0;
  logic        fault_vld = 1'b0;
  logic [1:0]  fault_id = '0;
  logic        cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        smi_pulse, nmi_pulse;

  always #2 clk = ~clk;

  dimm_err_monitor u0 (
    .clk(clk), .rst_n(rst_n), .mode_pair(mode_pair), .ev_valid(ev_valid),
    .ev_chan(ev_chan), .ev_mod(ev_mod), .ev_rank(ev_rank),
    .fault_vld(fault_vld), .fault_id(fault_id), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .smi_pulse(smi_pulse), .nmi_pulse(nmi_pulse)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int        m_cnt[8];
  bit [7:0]  m_ovf;
  bit [1:0]  m_fid;
  bit [16:0] m_ctrl;
  bit        m_smi, m_nmi;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_ovf = '0; m_fid = '0; m_ctrl = '0; m_smi = 0; m_nmi = 0;
    end else begin
      bit [7:0] setv, keep;
      int u;
      setv = '0;
      if (ev_valid) begin
        if (mode_pair) u = ev_chan * 4 + (ev_mod % 2) * 2 + ev_rank / 2;
        else           u = ev_chan * 4 + ev_mod;
        if (m_cnt[u] < 32767) m_cnt[u] = m_cnt[u] + 1;
        if (m_cnt[u] > int'(m_ctrl[14:0])) setv[u] = 1'b1;
      end
      keep = (cfg_we && !cfg_addr) ? (m_ovf & cfg_wdata[7:0]) : m_ovf;
      m_smi = ((setv & ~m_ovf) != 0) && m_ctrl[15];
      m_nmi = ((setv & ~m_ovf) != 0) && m_ctrl[16] && !m_ctrl[15];
      m_ovf = keep | setv;
      if (fault_vld) m_fid = fault_id;
      else if (cfg_we && !cfg_addr) m_fid = m_fid & cfg_wdata[13:12];
      if (cfg_we && cfg_addr) m_ctrl = cfg_wdata[16:0];
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R9 smi_pulse vs model", {31'b0, smi_pulse}, {31'b0, m_smi});
      chk("R9 nmi_pulse vs model", {31'b0, nmi_pulse}, {31'b0, m_nmi});
      if (cfg_addr) chk("R2 control read vs model", cfg_rdata, {15'b0, m_ctrl});
      else          chk("R7 status read vs model", cfg_rdata, {18'b0, m_fid, 4'b0, m_ovf});
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_addr = a; #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic ev(input logic c, input logic [1:0] m, input logic [1:0] r,
                    output logic s, output logic n);
    @(negedge clk); ev_valid = 1'b1; ev_chan = c; ev_mod = m; ev_rank = r;
    @(negedge clk); ev_valid = 1'b0; s = smi_pulse; n = nmi_pulse;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic s, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(1'b0, 32'h0, "R1 status after reset");
    rd(1'b1, 32'h0, "R1 control after reset");
    // R2/R10: control readback and reserved bits
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, 32'h0001_FFFF, "R2 R10 control all-ones readback");
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, 32'h0, "R7 R10 writing ones to status sets nothing");
    wr(1'b1, 32'h0000_8003);
    rd(1'b1, 32'h0000_8003, "R2 threshold 3 with smi enable");
    // R3/R5: unit 2 in module mode
    for (int i = 0; i < 3; i++) begin
      ev(1'b0, 2'd2, 2'd0, s, n);
      chk("R3 no pulse while count <= threshold", {31'b0, s}, 32'h0);
    end
    rd(1'b0, 32'h0, "R3 count equal to threshold leaves flag clear");
    ev(1'b0, 2'd2, 2'd0, s, n);
    chk("R9 smi pulse on new flag", {30'b0, s, n}, 32'h2);
    rd(1'b0, 32'h04, "R5 chan0 module2 maps to bit2");
    ev(1'b0, 2'd2, 2'd0, s, n);
    chk("R9 no pulse when flag already set", {30'b0, s, n}, 32'h0);
    for (int i = 0; i < 4; i++) ev(1'b1, 2'd3, 2'd1, s, n);
    chk("R9 smi pulse chan1 module3", {30'b0, s, n}, 32'h2);
    rd(1'b0, 32'h84, "R5 chan1 module3 maps to bit7");
    wr(1'b0, 32'h0000_0080);
    rd(1'b0, 32'h80, "R7 write zero clears bit2 only");
    // R6: rank-pair mode with nmi only
    mode_pair = 1'b1;
    wr(1'b1, 32'h0001_0003);
    for (int i = 0; i < 4; i++) ev(1'b1, 2'd0, 2'd3, s, n);
    chk("R9 nmi pulse when only nmi enabled", {30'b0, s, n}, 32'h1);
    rd(1'b0, 32'hA0, "R6 chan1 module0 ranks2-3 maps to bit5");
    ev(1'b0, 2'd3, 2'd0, s, n);
    chk("R6 module bit1 ignored, lands on unit2", {30'b0, s, n}, 32'h1);
    rd(1'b0, 32'hA4, "R6 chan0 module1 ranks0-1 maps to bit2");
    // R9: no enables, no pulse
    wr(1'b1, 32'h0000_0003);
    for (int i = 0; i < 4; i++) begin
      ev(1'b0, 2'd0, 2'd1, s, n);
      chk("R9 no pulse with both enables clear", {30'b0, s, n}, 32'h0);
    end
    rd(1'b0, 32'hA5, "R6 chan0 module0 ranks0-1 maps to bit0");
    // R9: both enabled -> smi wins
    wr(1'b1, 32'h0001_8003);
    wr(1'b0, 32'h0);
    rd(1'b0, 32'h0, "R7 write zeros clears all flags");
    ev(1'b0, 2'd1, 2'd1, s, n);
    chk("R9 smi wins when both enabled", {30'b0, s, n}, 32'h2);
    // R7: clear and hardware set in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = 32'h0;
    ev_valid = 1'b1; ev_chan = 1'b0; ev_mod = 2'd0; ev_rank = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; ev_valid = 1'b0;
    chk("R7 R9 pulse for set that beats clear", {31'b0, smi_pulse}, 32'h1);
    rd(1'b0, 32'h01, "R7 hardware set wins over clearing write");
    // R8: redundancy-loss id
    @(negedge clk); fault_vld = 1'b1; fault_id = 2'd3;
    @(negedge clk); fault_vld = 1'b0;
    chk("R8 no interrupt on redundancy loss", {30'b0, smi_pulse, nmi_pulse}, 32'h0);
    rd(1'b0, 32'h3001, "R8 failing id loaded into bits 13:12");
    wr(1'b0, 32'hFFFF_EFFF);
    rd(1'b0, 32'h2001, "R8 write zero clears bit12 only");
    // R4: saturation on unit 4 (module mode, chan1 module0)
    mode_pair = 1'b0;
    wr(1'b0, 32'hFFFF_FF00);
    wr(1'b1, 32'h0000_8000 | 32'd32766);
    @(negedge clk); ev_valid = 1'b1; ev_chan = 1'b1; ev_mod = 2'd0; ev_rank = 2'd0;
    repeat (32767) @(negedge clk);
    ev_valid = 1'b0;
    rd(1'b0, 32'h2010, "R4 R3 flag set at count 32767");
    for (int i = 0; i < 5; i++) ev(1'b1, 2'd0, 2'd0, s, n);
    wr(1'b0, 32'hFFFF_FF00);
    rd(1'b0, 32'h2000, "R7 flag cleared before saturation probe");
    ev(1'b1, 2'd0, 2'd0, s, n);
    chk("R4 saturated counter still above threshold", {30'b0, s, n}, 32'h2);
    rd(1'b0, 32'h2010, "R4 counter did not wrap");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule